// File: doc/BRIEF.md
# String Move, Fill, Search and Compare Sequencer

This block carries out processor string instructions against a single synchronous memory port. A command works on three registers. The first pointer holds the destination or search address. The second holds either a source pointer or a comparison value. A count holds the number of elements that remain. The sequencer issues one memory access per cycle and steps the pointers. It decrements the count and stops on the rule the command defines. It then reports the final register values and the zero (Z) and carry (C) flags.

The command is a 3-bit code: 0 forward byte copy, 1 backward byte copy, 2 byte copy that stops at NUL, 3 fill, 4 search until an element equals the value, 5 search while elements equal the value, 6 byte-string compare. Code 7 is illegal. The size input selects the element width for fill and the searches: 0 is one byte, 1 is two bytes, 2 is four bytes, and 3 is illegal. Multi-byte elements are little-endian. The caller pulses `start` while `busy` is low and waits for a one-cycle `done` or `err` pulse.

Top module: `strop_engine`

## Requirements
- R1: If the count is zero at start, `done` pulses in the next cycle with no memory access. The registers take the start values and both flags keep their previous values.
- R2: Command 0 copies the byte at the second pointer to the first pointer, adds 1 to both pointers and subtracts 1 from the count, and repeats until the count is zero.
- R3: Command 1 behaves like command 0, but subtracts 1 from both pointers.
- R4: Command 2 copies forward like command 0, and also finishes right after a zero byte is stored, whatever count remains.
- R5: Command 3 stores the low 1, 2 or 4 bytes of the second register at the first pointer (little-endian). It adds the element size to the first pointer and repeats until the count is zero.
- R6: Command 4 loads elements at the first pointer and stops on the first one equal to the second register (zero-extended compare). It then sets Z = (element == value) and C = (element <= value, unsigned).
- R7: Command 5 stops on the first element that differs from the value. It then sets Z = (remaining count == 0) and C = (element <= value, unsigned).
- R8: Command 6 reads one byte at each pointer and stops on a mismatch or on a NUL byte. It then sets Z = (bytes equal) and C = (first byte >= second byte, unsigned).
- R9: For every element examined, including the last, the pointers step and the count drops by one, so the final registers point past the last element examined. The count never wraps below zero.
- R10: Command 7 or size 3 gives an `err` pulse in the next cycle, makes no memory access, and leaves registers and flags unchanged.
- R11: The memory port never reads and writes in the same cycle. Read data is expected one cycle after `memRe`. `memSize` encodes the access width as the size code, and copies and compares use byte accesses.
- R12: After reset the engine is idle: `busy`, `done`, `err`, `memRe`, `memWe`, both flags and all three registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a command (taken while idle) |
| cmd | input | 3 | Command code |
| size | input | 2 | Element size code |
| r1In | input | REG_W | Initial first pointer |
| r2In | input | REG_W | Initial second pointer or value |
| r3In | input | CNT_W | Initial count |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command finished (one cycle) |
| err | output | 1 | Command rejected (one cycle) |
| r1Out | output | REG_W | First pointer |
| r2Out | output | REG_W | Second pointer or value |
| r3Out | output | CNT_W | Remaining count |
| flagZ | output | 1 | Zero flag |
| flagC | output | 1 | Carry flag |
| memAddr | output | REG_W | Memory byte address |
| memSize | output | 2 | Access width code |
| memRe | output | 1 | Read request |
| memWe | output | 1 | Write request |
| memWdata | output | 32 | Write data, low bytes used |
| memRdata | input | 32 | Read data, zero-extended, one cycle after the request |

## Verification
The bench builds the engine with REG_W = 32 and CNT_W = 6. The narrow count lets a single command reach the largest count of 63 and walk a long run of memory within a short run. Pointers keep their full 32-bit width, so backward copies that step below address zero wrap as they would in a real machine. The memory model decodes only the low eight address bits. Random commands therefore often overlap source and destination, and searches and compares often meet equal elements and NUL bytes.

// File: rtl/strop_pkg.sv
package strop_pkg;

  typedef enum logic [2:0] {
    CMD_CPYF = 3'd0,
    CMD_CPYB = 3'd1,
    CMD_CPYZ = 3'd2,
    CMD_FILL = 3'd3,
    CMD_SUNT = 3'd4,
    CMD_SWHL = 3'd5,
    CMD_SCMP = 3'd6,
    CMD_BAD  = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    FL_NONE,
    FL_UNTIL,
    FL_WHILE,
    FL_CMP
  } flag_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic  load;
    logic  rdReq;
    logic  wrReq;
    logic  addrR2;
    logic  useSize;
    logic  wrFromMem;
    logic  stepR1;
    logic  stepR2;
    logic  stepBack;
    logic  stepElt;
    logic  decR3;
    logic  latchA;
    flag_e flagMode;
  } strobe_t;

  // conditions reported back by the datapath
  typedef struct packed {
    logic lastElt;
    logic eltEq;
    logic byteNul;
    logic aNul;
    logic bytesEq;
  } status_t;

endpackage

// File: rtl/strop_datapath.sv
module strop_datapath
  import strop_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int CNT_W  = 16,
  parameter int LANE_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [REG_W-1:0]  r1In,
  input  logic [REG_W-1:0]  r2In,
  input  logic [CNT_W-1:0]  r3In,
  input  logic [1:0]        sizeIn,
  input  logic [LANE_W-1:0] memRdata,
  output logic [REG_W-1:0]  memAddr,
  output logic [1:0]        memSize,
  output logic              memRe,
  output logic              memWe,
  output logic [LANE_W-1:0] memWdata,
  output logic [REG_W-1:0]  r1,
  output logic [REG_W-1:0]  r2,
  output logic [CNT_W-1:0]  r3,
  output logic              flagZ,
  output logic              flagC,
  output status_t           status
);

  logic [1:0]        sizeReg;
  logic [7:0]        tmpA;
  logic [LANE_W-1:0] eltRaw;
  logic [REG_W-1:0]  eltVal;
  logic [REG_W-1:0]  stepAmt;
  logic [7:0]        curByte;

  always_comb begin
    case (sizeReg)
      2'd0:    eltRaw = LANE_W'(memRdata[7:0]);
      2'd1:    eltRaw = LANE_W'(memRdata[15:0]);
      default: eltRaw = memRdata;
    endcase
  end

  assign eltVal  = REG_W'(eltRaw);
  assign curByte = memRdata[7:0];
  assign stepAmt = stb.stepElt ? (REG_W'(1) << sizeReg) : REG_W'(1);

  assign memAddr  = stb.addrR2 ? r2 : r1;
  assign memSize  = stb.useSize ? sizeReg : 2'd0;
  assign memRe    = stb.rdReq;
  assign memWe    = stb.wrReq;
  assign memWdata = stb.wrFromMem ? LANE_W'(curByte) : r2[LANE_W-1:0];

  assign status.lastElt = (r3 == CNT_W'(1));
  assign status.eltEq   = (eltVal == r2);
  assign status.byteNul = (curByte == 8'd0);
  assign status.aNul    = (tmpA == 8'd0);
  assign status.bytesEq = (tmpA == curByte);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      r1      <= '0;
      r2      <= '0;
      r3      <= '0;
      sizeReg <= '0;
      tmpA    <= '0;
      flagZ   <= 1'b0;
      flagC   <= 1'b0;
    end else begin
      if (stb.load) begin
        r1      <= r1In;
        r2      <= r2In;
        r3      <= r3In;
        sizeReg <= sizeIn;
      end else begin
        if (stb.stepR1) r1 <= stb.stepBack ? r1 - stepAmt : r1 + stepAmt;
        if (stb.stepR2) r2 <= stb.stepBack ? r2 - REG_W'(1) : r2 + REG_W'(1);
        if (stb.decR3)  r3 <= r3 - CNT_W'(1);
        if (stb.latchA) tmpA <= curByte;
      end
      case (stb.flagMode)
        FL_UNTIL: begin
          flagZ <= status.eltEq;
          flagC <= (eltVal <= r2);
        end
        FL_WHILE: begin
          flagZ <= status.lastElt;
          flagC <= (eltVal <= r2);
        end
        FL_CMP: begin
          flagZ <= status.bytesEq;
          flagC <= (tmpA >= curByte);
        end
        default: ;
      endcase
    end
  end

  // R9: the count is never stepped past zero
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.decR3 |-> r3 != '0);

  // R11: a single port, never read and write together
  p_single_access_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(memRe && memWe));

  // R11: a write that copies takes the byte returned by the read one cycle before
  p_copy_data_r11: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && stb.wrFromMem) |-> $past(memRe));

endmodule

// File: rtl/strop_control.sv
module strop_control
  import strop_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [2:0] cmd,
  input  logic [1:0] size,
  input  logic       r3InZero,
  input  status_t    status,
  output strobe_t    stb,
  output logic       busy,
  output logic       done,
  output logic       err
);

  typedef enum logic [2:0] {
    S_IDLE, S_RDA, S_RDB, S_WR, S_EVAL, S_FIN, S_ERR
  } state_e;

  state_e state, nextState;
  cmd_e   cmdReg;
  logic   illegal;
  logic   stop;

  assign illegal = (cmd == CMD_BAD) || (size == 2'd3);

  always_comb begin
    stb       = '0;
    nextState = state;
    stop      = 1'b0;
    case (state)
      S_IDLE: begin
        if (start) begin
          if (illegal) begin
            nextState = S_ERR;
          end else begin
            stb.load = 1'b1;
            if (r3InZero)                  nextState = S_FIN;
            else if (cmd == CMD_FILL)      nextState = S_WR;
            else                           nextState = S_RDA;
          end
        end
      end
      S_RDA: begin
        stb.rdReq = 1'b1;
        case (cmdReg)
          CMD_SUNT, CMD_SWHL: begin
            stb.useSize = 1'b1;
            nextState   = S_EVAL;
          end
          CMD_SCMP: nextState = S_RDB;
          default: begin
            stb.addrR2 = 1'b1;
            nextState  = S_WR;
          end
        endcase
      end
      S_RDB: begin
        stb.rdReq  = 1'b1;
        stb.addrR2 = 1'b1;
        stb.latchA = 1'b1;
        nextState  = S_EVAL;
      end
      S_WR: begin
        stb.wrReq  = 1'b1;
        stb.stepR1 = 1'b1;
        stb.decR3  = 1'b1;
        if (cmdReg == CMD_FILL) begin
          stb.useSize = 1'b1;
          stb.stepElt = 1'b1;
          stop        = status.lastElt;
          nextState   = stop ? S_FIN : S_WR;
        end else begin
          stb.wrFromMem = 1'b1;
          stb.stepR2    = 1'b1;
          stb.stepBack  = (cmdReg == CMD_CPYB);
          stop = status.lastElt || ((cmdReg == CMD_CPYZ) && status.byteNul);
          nextState = stop ? S_FIN : S_RDA;
        end
      end
      S_EVAL: begin
        stb.stepR1 = 1'b1;
        stb.decR3  = 1'b1;
        if (cmdReg == CMD_SCMP) begin
          stb.stepR2 = 1'b1;
          stop = status.lastElt || !status.bytesEq || status.aNul;
          if (stop) stb.flagMode = FL_CMP;
        end else begin
          stb.stepElt = 1'b1;
          stb.useSize = 1'b1;
          if (cmdReg == CMD_SUNT) begin
            stop = status.lastElt || status.eltEq;
            if (stop) stb.flagMode = FL_UNTIL;
          end else begin
            stop = status.lastElt || !status.eltEq;
            if (stop) stb.flagMode = FL_WHILE;
          end
        end
        nextState = stop ? S_FIN : S_RDA;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      cmdReg <= CMD_CPYF;
    end else begin
      state <= nextState;
      if (stb.load) cmdReg <= cmd_e'(cmd);
    end
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_FIN);
  assign err  = (state == S_ERR);

  // R10: illegal command or size is rejected at once, without touching memory
  p_illegal_err_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && start && illegal) |=> (err && !stb.rdReq && !stb.wrReq));

  // R4: a stored zero byte ends the NUL-terminated copy
  p_nul_stop_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WR && cmdReg == CMD_CPYZ && status.byteNul) |=> done);

  // R6 R7 R8: flags are written only on the final element of a search or compare
  p_flag_final_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.flagMode != FL_NONE) |=> done);

endmodule

// File: rtl/strop_engine.sv
module strop_engine
  import strop_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [2:0]       cmd,
  input  logic [1:0]       size,
  input  logic [REG_W-1:0] r1In,
  input  logic [REG_W-1:0] r2In,
  input  logic [CNT_W-1:0] r3In,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [REG_W-1:0] r1Out,
  output logic [REG_W-1:0] r2Out,
  output logic [CNT_W-1:0] r3Out,
  output logic             flagZ,
  output logic             flagC,
  output logic [REG_W-1:0] memAddr,
  output logic [1:0]       memSize,
  output logic             memRe,
  output logic             memWe,
  output logic [31:0]      memWdata,
  input  logic [31:0]      memRdata
);

  localparam int LANE_W = 32;

  strobe_t stb;
  status_t status;

  strop_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .cmd      (cmd),
    .size     (size),
    .r3InZero (r3In == '0),
    .status   (status),
    .stb      (stb),
    .busy     (busy),
    .done     (done),
    .err      (err)
  );

  strop_datapath #(.REG_W(REG_W), .CNT_W(CNT_W), .LANE_W(LANE_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .r1In     (r1In),
    .r2In     (r2In),
    .r3In     (r3In),
    .sizeIn   (size),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memSize  (memSize),
    .memRe    (memRe),
    .memWe    (memWe),
    .memWdata (memWdata),
    .r1       (r1Out),
    .r2       (r2Out),
    .r3       (r3Out),
    .flagZ    (flagZ),
    .flagC    (flagC),
    .status   (status)
  );

  // R1: zero count finishes next cycle, quietly, with flags kept
  p_zero_count_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && cmd != 3'd7 && size != 2'd3 && r3In == '0)
      |=> (done && $stable({flagZ, flagC}) && !memRe && !memWe));

endmodule

// File: tb/tb_strop_engine.sv
`timescale 1ns/1ps
module tb_strop_engine;
  localparam int REG_W = 32;
  localparam int CNT_W = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rstN, start;
  logic [2:0]       cmd;
  logic [1:0]       size;
  logic [REG_W-1:0] r1In, r2In;
  logic [CNT_W-1:0] r3In;
  logic             busy, done, err, flagZ, flagC, memRe, memWe;
  logic [REG_W-1:0] r1Out, r2Out, memAddr;
  logic [CNT_W-1:0] r3Out;
  logic [1:0]       memSize;
  logic [31:0]      memWdata, memRdata;

  strop_engine #(.REG_W(REG_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .start(start), .cmd(cmd), .size(size),
    .r1In(r1In), .r2In(r2In), .r3In(r3In), .busy(busy), .done(done), .err(err),
    .r1Out(r1Out), .r2Out(r2Out), .r3Out(r3Out), .flagZ(flagZ), .flagC(flagC),
    .memAddr(memAddr), .memSize(memSize), .memRe(memRe), .memWe(memWe),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  logic [7:0] mem    [256];
  logic [7:0] refMem [256];
  int accCnt;
  int cycles;
  int nChk = 0, nBad = 0;

  // memory model: one-cycle read latency, byte lanes little-endian
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (memRe || memWe) accCnt <= accCnt + 1;
    if (memRe) begin
      logic [31:0] d;
      d = '0;
      for (int i = 0; i < (1 << memSize); i++) d[8*i +: 8] = mem[8'(memAddr + i)];
      memRdata <= d;
    end
    if (memWe)
      for (int i = 0; i < (1 << memSize); i++) mem[8'(memAddr + i)] <= memWdata[8*i +: 8];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ld(input logic [31:0] a, input int sz);
    logic [31:0] v = '0;
    for (int i = 0; i < (1 << sz); i++) v[8*i +: 8] = refMem[8'(a + i)];
    return v;
  endfunction

  // reference model written from the requirements
  task automatic refRun(input int c, input int sz, inout logic [31:0] a1,
                        inout logic [31:0] a2, inout logic [CNT_W-1:0] c3,
                        inout logic fz, inout logic fc);
    logic [31:0] e, b;
    int step;
    step = 1 << sz;
    if (c3 == 0) return;
    case (c)
      0, 1, 2: while (c3 != 0) begin
        e = 32'(refMem[a2[7:0]]);
        refMem[a1[7:0]] = e[7:0];
        if (c == 1) begin a1 = a1 - 1; a2 = a2 - 1; end
        else begin a1 = a1 + 1; a2 = a2 + 1; end
        c3 = c3 - 1;
        if (c == 2 && e == 0) break;
      end
      3: while (c3 != 0) begin
        for (int i = 0; i < step; i++) refMem[8'(a1 + i)] = a2[8*i +: 8];
        a1 = a1 + step;
        c3 = c3 - 1;
      end
      4, 5: begin
        do begin
          e = ld(a1, sz);
          a1 = a1 + step;
          c3 = c3 - 1;
          if (c == 4 ? (e == a2) : (e != a2)) break;
        end while (c3 != 0);
        fz = (c == 4) ? (e == a2) : (c3 == 0);
        fc = (e <= a2);
      end
      default: begin
        do begin
          e = 32'(refMem[a1[7:0]]);
          b = 32'(refMem[a2[7:0]]);
          a1 = a1 + 1;
          a2 = a2 + 1;
          c3 = c3 - 1;
          if (e != b || e == 0) break;
        end while (c3 != 0);
        fz = (e == b);
        fc = (e >= b);
      end
    endcase
  endtask

  function automatic string reqOf(input int c);
    case (c)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic runOp(input int c, input int sz, input logic [31:0] a1,
                       input logic [31:0] a2, input logic [CNT_W-1:0] c3);
    logic [31:0] e1, e2;
    logic [CNT_W-1:0] e3;
    logic fz, fc;
    bit bad;
    int w, memBad;
    string rq;
    bad = (c == 7) || (sz == 3);
    fz = flagZ; fc = flagC;
    for (int i = 0; i < 256; i++) refMem[i] = mem[i];
    if (bad) begin
      e1 = r1Out; e2 = r2Out; e3 = r3Out;
    end else begin
      e1 = a1; e2 = a2; e3 = c3;
      refRun(c, sz, e1, e2, e3, fz, fc);
    end
    rq = bad ? "R10" : (c3 == 0 ? "R1" : reqOf(c));
    @(negedge clk);
    accCnt = 0;
    start = 1'b1; cmd = 3'(c); size = 2'(sz); r1In = a1; r2In = a2; r3In = c3;
    @(negedge clk);
    start = 1'b0;
    w = 0;
    while (!(done || err) && w < 3000) begin @(negedge clk); w++; end
    if (bad) begin
      chk(err == 1'b1 && done == 1'b0, "R10", "err pulse", err, 1);
      chk(accCnt == 0, "R10", "accesses", accCnt, 0);
    end else begin
      chk(done == 1'b1 && err == 1'b0, rq, "done pulse", done, 1);
      if (c3 == 0) chk(accCnt == 0, "R1", "accesses", accCnt, 0);
    end
    chk(r1Out == e1, {rq, "/R9"}, "r1", r1Out, e1);
    chk(r2Out == e2, {rq, "/R9"}, "r2", r2Out, e2);
    chk(r3Out == e3, {rq, "/R9"}, "r3", r3Out, e3);
    chk(flagZ == fz, rq, "Z", flagZ, fz);
    chk(flagC == fc, rq, "C", flagC, fc);
    memBad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== refMem[i]) memBad++;
    chk(memBad == 0, rq, "memory bytes wrong", memBad, 0);
  endtask

  task automatic fillMem(input int maxv);
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom_range(0, maxv));
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(negedge clk);
      if (cycles > 150000) begin
        nChk++; nBad++;
        $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; start = 1'b0; cmd = '0; size = '0;
    r1In = '0; r2In = '0; r3In = '0; accCnt = 0; memRdata = '0;
    fillMem(255);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12: reset state
    chk(!busy && !done && !err && !memRe && !memWe, "R12", "idle strobes",
        {busy, done, err, memRe, memWe}, 0);
    chk(!flagZ && !flagC && r1Out == 0 && r2Out == 0 && r3Out == 0, "R12",
        "regs and flags", r1Out ^ r2Out ^ 32'(r3Out), 0);

    // directed cases
    fillMem(3);
    runOp(0, 0, 32'h40, 32'h10, 6'd5);        // R2 forward copy
    runOp(1, 0, 32'h23, 32'h20, 6'd6);        // R3 backward, overlapping
    runOp(1, 0, 32'h2, 32'h80, 6'd5);         // R3 pointer wraps below zero
    mem[8'h62] = 8'h00; mem[8'h60] = 8'h07; mem[8'h61] = 8'h09;
    runOp(2, 0, 32'h90, 32'h60, 6'd10);       // R4 stops after NUL
    runOp(3, 2, 32'hA0, 32'h11223344, 6'd3);  // R5 word fill
    runOp(3, 1, 32'hC1, 32'hBEEF, 6'd4);      // R5 half fill
    runOp(3, 0, 32'h0, 32'h5A, 6'd63);        // R5 largest count
    mem[8'h33] = 8'h02;
    runOp(4, 0, 32'h30, 32'h2, 6'd8);         // R6
    for (int i = 0; i < 8; i++) mem[8'h50 + i] = 8'h01;
    runOp(5, 0, 32'h50, 32'h1, 6'd8);         // R7 all equal, runs out
    mem[8'h54] = 8'h03;
    runOp(5, 0, 32'h50, 32'h1, 6'd8);         // R7 mismatch early
    for (int i = 0; i < 4; i++) begin mem[8'h70 + i] = 8'(i + 1); mem[8'h78 + i] = 8'(i + 1); end
    mem[8'h74] = 0; mem[8'h7C] = 0;
    runOp(6, 0, 32'h70, 32'h78, 6'd20);       // R8 equal strings, NUL end
    mem[8'h7A] = 8'h09;
    runOp(6, 0, 32'h70, 32'h78, 6'd20);       // R8 mismatch, first smaller
    runOp(0, 0, 32'h10, 32'h20, 6'd0);        // R1 zero count, flags kept
    runOp(6, 3, 32'h10, 32'h20, 6'd4);        // R10 size 3
    runOp(7, 0, 32'h10, 32'h20, 6'd4);        // R10 command 7

    // constrained random
    for (int n = 0; n < 300; n++) begin
      int c, sz;
      if (n % 10 == 0) fillMem((n % 20 == 0) ? 255 : 3);
      c  = $urandom_range(0, 6);
      sz = (c == 3 || c == 4 || c == 5) ? $urandom_range(0, 2) : 0;
      if ($urandom_range(0, 40) == 0) c = 7;
      runOp(c, sz, 32'($urandom_range(0, 255)),
            (c == 3 || c == 4 || c == 5) ? 32'($urandom_range(0, 3)) : 32'($urandom_range(0, 255)),
            CNT_W'($urandom_range(0, 20)));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule